// File: doc/BRIEF.md
# Outstanding Non-Posted Request Tracker

This block keeps account of the non-posted requests that one I/O stream has in flight on a packet link. When the stream issues a non-posted request, the tracker hands out the lowest free 5-bit source tag and records the kind of request: read, non-posted write, atomic or flush. A posted request passes through without consuming a tag, because no response will come back for it.

When a response arrives, the tracker looks up its tag. It reports a completion carrying the recorded request kind and a classification: normal, master abort or target abort. It then sets the matching sticky status bit and releases the tag. Reads and atomics are always followed by their data in full, even when the response carries an error. For these the tag stays owned until the last data beat has passed, and beats that belong to a failed response are flagged for discard. A response to a tag that is not pending, or a data beat with no response in progress, counts as a protocol error. If the link drops while any request is still pending, a chain-down error is raised. All status bits are cleared by writing ones to them.

Top module: `np_tag_tracker`

## Requirements
- R1: After reset no tag is pending, `issueTag` is 0, `issueReady` and `respReady` are high while `linkUp` is high, `status` is 0 and `cmplValid` is low.
- R2: A non-posted issue (`issueValid` and `issueReady` high with `issuePosted` low) takes the tag shown on `issueTag`, which is always the lowest free tag. A tag that is freed at a clock edge is shown again from the following cycle.
- R3: A posted issue takes no tag, so `issueTag` is unchanged afterwards. It is accepted even when every tag is busy.
- R4: `issueReady` is low for a non-posted issue while all 32 tags are busy, and it is low for any issue while `linkUp` is low.
- R5: One cycle after a response to a pending tag is taken, `cmplValid` is high for one cycle with `cmplTag`, the recorded `cmplType` (0 read, 1 write, 2 atomic, 3 flush) and `cmplKind` (0 normal, 1 master abort, 2 target abort). With `respErr` low, the response is normal whatever `respNxa` is.
- R6: A response with `respErr` and `respNxa` both high is a master abort and sets `status[0]`.
- R7: A response with `respErr` high and `respNxa` low is a target abort and sets `status[1]`.
- R8: A response to a tag that is not pending, or a data beat while no read or atomic response is in progress, sets `status[3]`. Such a response gives no completion and frees no tag.
- R9: A write or flush response frees its tag at once. A read or atomic response keeps its tag and holds `respReady` low until a beat with `dataLast`. During that time `dataTag` names the owning tag and `dataDiscard` is high on every beat of an errored response.
- R10: While `linkUp` is low and at least one tag is pending, `status[2]` (chain down) is set from the next cycle. Link down with nothing pending sets nothing.
- R11: Status bits are sticky and are cleared by writing a one to the matching bit of `statusClr`. A new event in the same cycle as the clear wins.
- R12: Reset releases every pending tag, so a response to a tag issued before reset is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkUp | input | 1 | Link is operational |
| issueValid | input | 1 | Request offered by the stream |
| issuePosted | input | 1 | Offered request is posted |
| issueType | input | 2 | Request kind: 0 read, 1 write, 2 atomic, 3 flush |
| issueReady | output | 1 | Offered request may be accepted |
| issueTag | output | 5 | Tag a non-posted issue takes this cycle |
| respValid | input | 1 | Response header present |
| respReady | output | 1 | Tracker accepts a response this cycle |
| respTag | input | 5 | Tag carried by the response |
| respErr | input | 1 | Error bit of the response |
| respNxa | input | 1 | Non-existent-address bit of the response |
| cmplValid | output | 1 | Completion report valid |
| cmplTag | output | 5 | Tag of the completed request |
| cmplType | output | 2 | Recorded request kind |
| cmplKind | output | 2 | 0 normal, 1 master abort, 2 target abort |
| dataValid | input | 1 | Response data beat present |
| dataLast | input | 1 | Final data beat |
| dataTag | output | 5 | Tag that owns the current data |
| dataDiscard | output | 1 | Current beat belongs to an errored response |
| statusClr | input | 4 | Write-one-to-clear for status |
| status | output | 4 | Sticky: 0 master abort, 1 target abort, 2 chain down, 3 protocol error |

## Verification
`issueReady`, `issueTag`, `respReady`, `dataTag` and `dataDiscard` are combinational on state and inputs. The bench therefore samples them one time step after driving, within the same low clock phase. Tag allocation and release, the completion report and every status bit are registered, so they are due at the falling edge that follows the rising edge on which the stimulus was taken. Each task drives on a falling edge, drops its stimulus on the next falling edge, and checks registered results right there, before the following rising edge can change them again. A next-lowest tag shown on `issueTag` is likewise checked in the cycle after the edge that took or freed a tag.

// File: rtl/npt_pkg.sv
package npt_pkg;

  localparam int TYPE_W = 2;
  localparam int KIND_W = 2;
  localparam int ST_W   = 4;

  localparam int ST_MASTER_ABORT = 0;
  localparam int ST_TARGET_ABORT = 1;
  localparam int ST_CHAIN_DOWN   = 2;
  localparam int ST_PROTO_ERR    = 3;

  typedef enum logic [TYPE_W-1:0] {
    REQ_READ   = 2'd0,
    REQ_WRITE  = 2'd1,
    REQ_ATOMIC = 2'd2,
    REQ_FLUSH  = 2'd3
  } reqType_e;

  typedef enum logic [KIND_W-1:0] {
    CMPL_NORMAL       = 2'd0,
    CMPL_MASTER_ABORT = 2'd1,
    CMPL_TARGET_ABORT = 2'd2
  } cmplKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic alloc;       // take lowest free tag
    logic freeResp;    // release the tag named by the response
    logic freeData;    // release the tag owning the data phase
    logic cmplLoad;    // register a completion report
    logic dataCapture; // remember owner tag and error for data phase
    logic setMa;
    logic setTa;
    logic setChain;
    logic setProto;
  } ctrlStrobe_t;

endpackage

// File: rtl/npt_dpath.sv
module npt_dpath
  import npt_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strb,
  input  logic [TYPE_W-1:0]   issueType,
  input  logic [TAG_W-1:0]    respTag,
  input  logic                respErr,
  input  logic                respNxa,
  input  logic [ST_W-1:0]     statusClr,
  output logic                anyFree,
  output logic                anyPending,
  output logic [TAG_W-1:0]    freeTag,
  output logic                respHit,
  output logic [TYPE_W-1:0]   respType,
  output logic                cmplValid,
  output logic [TAG_W-1:0]    cmplTag,
  output logic [TYPE_W-1:0]   cmplType,
  output logic [KIND_W-1:0]   cmplKind,
  output logic [TAG_W-1:0]    dataTag,
  output logic                dataErr,
  output logic [ST_W-1:0]     status
);

  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0]  validQ, validD;
  logic [TYPE_W-1:0] typeQ [NTAGS];
  logic [ST_W-1:0]   setVec;

  // Lowest-free priority pick
  always_comb begin
    freeTag = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (!validQ[i]) freeTag = TAG_W'(i);
    end
  end

  assign anyFree    = ~&validQ;
  assign anyPending = |validQ;
  assign respHit    = validQ[respTag];
  assign respType   = typeQ[respTag];

  // Per-entry occupancy update
  for (genvar g = 0; g < NTAGS; g++) begin : g_entry
    always_comb begin
      validD[g] = validQ[g];
      if (strb.alloc && freeTag == TAG_W'(g))     validD[g] = 1'b1;
      if (strb.freeResp && respTag == TAG_W'(g))  validD[g] = 1'b0;
      if (strb.freeData && dataTag == TAG_W'(g))  validD[g] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      for (int i = 0; i < NTAGS; i++) typeQ[i] <= '0;
    end else begin
      validQ <= validD;
      if (strb.alloc) typeQ[freeTag] <= issueType;
    end
  end

  function automatic logic [KIND_W-1:0] classify(input logic err, input logic nxa);
    if (!err)     return CMPL_NORMAL;
    else if (nxa) return CMPL_MASTER_ABORT;
    else          return CMPL_TARGET_ABORT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmplValid <= 1'b0;
      cmplTag   <= '0;
      cmplType  <= '0;
      cmplKind  <= '0;
      dataTag   <= '0;
      dataErr   <= 1'b0;
    end else begin
      cmplValid <= strb.cmplLoad;
      if (strb.cmplLoad) begin
        cmplTag  <= respTag;
        cmplType <= typeQ[respTag];
        cmplKind <= classify(respErr, respNxa);
      end
      if (strb.dataCapture) begin
        dataTag <= respTag;
        dataErr <= respErr;
      end
    end
  end

  always_comb begin
    setVec = '0;
    setVec[ST_MASTER_ABORT] = strb.setMa;
    setVec[ST_TARGET_ABORT] = strb.setTa;
    setVec[ST_CHAIN_DOWN]   = strb.setChain;
    setVec[ST_PROTO_ERR]    = strb.setProto;
  end

  // Sticky, write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~statusClr) | setVec;
  end

  assert_no_alloc_when_full_R4: assert property (@(posedge clk) disable iff (!rstN)
    !anyFree |-> !strb.alloc);

  assert_cmpl_from_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid |-> $past(respHit));

  assert_data_owner_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.freeData |-> validQ[dataTag]);

  assert_chain_down_sets_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.setChain |=> status[ST_CHAIN_DOWN]);

  assert_abort_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setMa && strb.setTa));

endmodule

// File: rtl/npt_ctrl.sv
module npt_ctrl
  import npt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              issueValid,
  input  logic              issuePosted,
  input  logic              respValid,
  input  logic              respErr,
  input  logic              respNxa,
  input  logic              respHit,
  input  logic [TYPE_W-1:0] respType,
  input  logic              dataValid,
  input  logic              dataLast,
  input  logic              anyFree,
  input  logic              anyPending,
  output logic              issueReady,
  output logic              respReady,
  output logic              dataPhase,
  output ctrlStrobe_t       strb
);

  typedef enum logic {ST_IDLE, ST_DATA} state_e;

  state_e stateQ, stateD;
  logic   respTake, hasData;

  assign issueReady = linkUp && (issuePosted || anyFree);
  assign respReady  = (stateQ == ST_IDLE);
  assign dataPhase  = (stateQ == ST_DATA);
  assign respTake   = respValid && respReady;
  assign hasData    = (respType == REQ_READ) || (respType == REQ_ATOMIC);

  always_comb begin
    strb             = '0;
    strb.alloc       = issueValid && issueReady && !issuePosted;
    strb.cmplLoad    = respTake && respHit;
    strb.freeResp    = respTake && respHit && !hasData;
    strb.dataCapture = respTake && respHit && hasData;
    strb.setMa       = respTake && respHit && respErr && respNxa;
    strb.setTa       = respTake && respHit && respErr && !respNxa;
    strb.setProto    = (respTake && !respHit) || (dataValid && !dataPhase);
    strb.setChain    = !linkUp && anyPending;
    strb.freeData    = dataPhase && dataValid && dataLast;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strb.dataCapture) stateD = ST_DATA;
      ST_DATA: if (dataValid && dataLast) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assert_hold_until_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataPhase && !(dataValid && dataLast)) |=> !respReady);

endmodule

// File: rtl/np_tag_tracker.sv
module np_tag_tracker
  import npt_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              issueValid,
  input  logic              issuePosted,
  input  logic [1:0]        issueType,
  output logic              issueReady,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              respValid,
  output logic              respReady,
  input  logic [TAG_W-1:0]  respTag,
  input  logic              respErr,
  input  logic              respNxa,
  output logic              cmplValid,
  output logic [TAG_W-1:0]  cmplTag,
  output logic [1:0]        cmplType,
  output logic [1:0]        cmplKind,
  input  logic              dataValid,
  input  logic              dataLast,
  output logic [TAG_W-1:0]  dataTag,
  output logic              dataDiscard,
  input  logic [3:0]        statusClr,
  output logic [3:0]        status
);

  ctrlStrobe_t       strb;
  logic              anyFree, anyPending, respHit, dataPhase, dataErr;
  logic [TYPE_W-1:0] respType;

  npt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .linkUp     (linkUp),
    .issueValid (issueValid),
    .issuePosted(issuePosted),
    .respValid  (respValid),
    .respErr    (respErr),
    .respNxa    (respNxa),
    .respHit    (respHit),
    .respType   (respType),
    .dataValid  (dataValid),
    .dataLast   (dataLast),
    .anyFree    (anyFree),
    .anyPending (anyPending),
    .issueReady (issueReady),
    .respReady  (respReady),
    .dataPhase  (dataPhase),
    .strb       (strb)
  );

  npt_dpath #(.TAG_W(TAG_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .issueType (issueType),
    .respTag   (respTag),
    .respErr   (respErr),
    .respNxa   (respNxa),
    .statusClr (statusClr),
    .anyFree   (anyFree),
    .anyPending(anyPending),
    .freeTag   (issueTag),
    .respHit   (respHit),
    .respType  (respType),
    .cmplValid (cmplValid),
    .cmplTag   (cmplTag),
    .cmplType  (cmplType),
    .cmplKind  (cmplKind),
    .dataTag   (dataTag),
    .dataErr   (dataErr),
    .status    (status)
  );

  assign dataDiscard = dataPhase && dataValid && dataErr;

  assert_blocked_resp_no_cmpl_R9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> !cmplValid);

endmodule

// File: tb/np_tag_tracker_tb_top.sv
module np_tag_tracker_tb_top;

  localparam int TAG_W = 5;
  localparam int NTAGS = 1 << TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic linkUp = 1'b1;
  logic issueValid = 1'b0, issuePosted = 1'b0;
  logic [1:0] issueType = 2'd0;
  logic issueReady;
  logic [TAG_W-1:0] issueTag;
  logic respValid = 1'b0, respErr = 1'b0, respNxa = 1'b0;
  logic [TAG_W-1:0] respTag = '0;
  logic respReady;
  logic cmplValid;
  logic [TAG_W-1:0] cmplTag;
  logic [1:0] cmplType, cmplKind;
  logic dataValid = 1'b0, dataLast = 1'b0;
  logic [TAG_W-1:0] dataTag;
  logic dataDiscard;
  logic [3:0] statusClr = 4'd0;
  logic [3:0] status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [NTAGS-1:0] busy = '0;

  always #2 clk = ~clk;

  np_tag_tracker #(.TAG_W(TAG_W)) dut_i (
    .clk(clk), .rstN(rstN), .linkUp(linkUp),
    .issueValid(issueValid), .issuePosted(issuePosted), .issueType(issueType),
    .issueReady(issueReady), .issueTag(issueTag),
    .respValid(respValid), .respReady(respReady), .respTag(respTag),
    .respErr(respErr), .respNxa(respNxa),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplType(cmplType), .cmplKind(cmplKind),
    .dataValid(dataValid), .dataLast(dataLast), .dataTag(dataTag), .dataDiscard(dataDiscard),
    .statusClr(statusClr), .status(status)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] lowestFree();
    for (int i = 0; i < NTAGS; i++) if (!busy[i]) return TAG_W'(i);
    return '0;
  endfunction

  task automatic issueNp(input logic [1:0] kind);
    @(negedge clk);
    issueValid = 1'b1; issuePosted = 1'b0; issueType = kind;
    #1;
    chk("R2", "issueReady", 32'(issueReady), 32'd1);
    chk("R2", "issueTag lowest free", 32'(issueTag), 32'(lowestFree()));
    busy[lowestFree()] = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic respond(input logic [TAG_W-1:0] tag, input logic err, input logic nxa);
    @(negedge clk);
    respValid = 1'b1; respTag = tag; respErr = err; respNxa = nxa;
    @(negedge clk);
    respValid = 1'b0; respErr = 1'b0; respNxa = 1'b0;
  endtask

  task automatic expectCmpl(input string req, input logic [TAG_W-1:0] tag,
                            input logic [1:0] kind, input logic [1:0] typ);
    chk(req, "cmplValid", 32'(cmplValid), 32'd1);
    chk(req, "cmplTag", 32'(cmplTag), 32'(tag));
    chk(req, "cmplKind", 32'(cmplKind), 32'(kind));
    chk(req, "cmplType", 32'(cmplType), 32'(typ));
  endtask

  task automatic dataBeat(input logic last, input logic expDiscard, input logic [TAG_W-1:0] expTag, input bit chkTag);
    @(negedge clk);
    dataValid = 1'b1; dataLast = last;
    #1;
    chk("R9", "dataDiscard", 32'(dataDiscard), 32'(expDiscard));
    if (chkTag) chk("R9", "dataTag", 32'(dataTag), 32'(expTag));
    @(negedge clk);
    dataValid = 1'b0; dataLast = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk);
    statusClr = 4'hf;
    @(negedge clk);
    statusClr = 4'h0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1", "issueTag", 32'(issueTag), 32'd0);
    chk("R1", "issueReady", 32'(issueReady), 32'd1);
    chk("R1", "respReady", 32'(respReady), 32'd1);
    chk("R1", "status", 32'(status), 32'd0);
    chk("R1", "cmplValid", 32'(cmplValid), 32'd0);
  endtask

  task automatic t_alloc();
    issueNp(2'd0); // tag 0 read
    issueNp(2'd1); // tag 1 write
    issueNp(2'd3); // tag 2 flush
    @(negedge clk);
    issueValid = 1'b1; issuePosted = 1'b1; issueType = 2'd1;
    #1;
    chk("R3", "posted issueReady", 32'(issueReady), 32'd1);
    @(negedge clk);
    issueValid = 1'b0; issuePosted = 1'b0;
    #1;
    chk("R3", "tag unchanged after posted", 32'(issueTag), 32'd3);
  endtask

  task automatic t_write_normal();
    respond(5'd1, 1'b0, 1'b1); // nxa without err: normal
    expectCmpl("R5", 5'd1, 2'd0, 2'd1);
    busy[1] = 1'b0;
    #1;
    chk("R2", "freed tag reused next cycle", 32'(issueTag), 32'd1);
    chk("R5", "no status on normal", 32'(status), 32'd0);
  endtask

  task automatic t_flush_ma();
    respond(5'd2, 1'b1, 1'b1);
    expectCmpl("R6", 5'd2, 2'd1, 2'd3);
    chk("R6", "master abort status", 32'(status), 32'b0001);
    busy[2] = 1'b0;
  endtask

  task automatic t_read_ta();
    issueNp(2'd1); // tag 1 write
    respond(5'd0, 1'b1, 1'b0);
    expectCmpl("R7", 5'd0, 2'd2, 2'd0);
    chk("R7", "target abort status", 32'(status), 32'b0011);
    #1;
    chk("R9", "respReady low in data", 32'(respReady), 32'd0);
    chk("R9", "read tag still held", 32'(issueTag), 32'd2);
    dataBeat(1'b0, 1'b1, 5'd0, 1'b1);
    dataBeat(1'b1, 1'b1, 5'd0, 1'b1);
    busy[0] = 1'b0;
    #1;
    chk("R9", "tag freed after last", 32'(issueTag), 32'd0);
    chk("R9", "respReady back", 32'(respReady), 32'd1);
  endtask

  task automatic t_atomic_normal();
    issueNp(2'd2); // tag 0 atomic
    respond(5'd0, 1'b0, 1'b0);
    expectCmpl("R5", 5'd0, 2'd0, 2'd2);
    dataBeat(1'b1, 1'b0, 5'd0, 1'b1);
    busy[0] = 1'b0;
    #1;
    chk("R9", "atomic tag freed", 32'(issueTag), 32'd0);
  endtask

  task automatic t_proto();
    clearAll();
    chk("R11", "cleared", 32'(status), 32'd0);
    respond(5'd7, 1'b0, 1'b0);
    chk("R8", "no cmpl on miss", 32'(cmplValid), 32'd0);
    chk("R8", "proto status", 32'(status), 32'b1000);
    #1;
    chk("R8", "miss frees nothing", 32'(issueTag), 32'd0);
    clearAll();
    dataBeat(1'b1, 1'b0, '0, 1'b0);
    chk("R8", "stray data proto", 32'(status), 32'b1000);
    // set wins over clear in the same cycle
    @(negedge clk);
    respValid = 1'b1; respTag = 5'd9; statusClr = 4'b1000;
    @(negedge clk);
    respValid = 1'b0; statusClr = 4'b0000;
    chk("R11", "set wins", 32'(status), 32'b1000);
    clearAll();
    chk("R11", "clear bit3", 32'(status), 32'd0);
  endtask

  task automatic t_full();
    while (busy != '1) issueNp(2'd1);
    @(negedge clk);
    issueValid = 1'b0; issuePosted = 1'b0;
    #1;
    chk("R4", "full not ready", 32'(issueReady), 32'd0);
    issuePosted = 1'b1;
    #1;
    chk("R3", "posted ready when full", 32'(issueReady), 32'd1);
    issuePosted = 1'b0;
    respond(5'd5, 1'b0, 1'b0);
    expectCmpl("R5", 5'd5, 2'd0, 2'd1);
    busy[5] = 1'b0;
    #1;
    chk("R4", "ready after free", 32'(issueReady), 32'd1);
    chk("R2", "freed tag shown", 32'(issueTag), 32'd5);
  endtask

  task automatic t_chain();
    @(negedge clk);
    linkUp = 1'b0;
    #1;
    chk("R4", "not ready link down", 32'(issueReady), 32'd0);
    @(negedge clk);
    linkUp = 1'b1;
    chk("R10", "chain down", 32'(status), 32'b0100);
  endtask

  task automatic t_flush_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    busy = '0;
    #1;
    chk("R12", "issueTag after reset", 32'(issueTag), 32'd0);
    chk("R12", "status after reset", 32'(status), 32'd0);
    respond(5'd3, 1'b0, 1'b0);
    chk("R12", "old tag no cmpl", 32'(cmplValid), 32'd0);
    chk("R12", "old tag proto", 32'(status), 32'b1000);
    clearAll();
    @(negedge clk);
    linkUp = 1'b0;
    @(negedge clk);
    linkUp = 1'b1;
    chk("R10", "no chain down when idle", 32'(status), 32'd0);
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_write_normal();
    t_flush_ma();
    t_read_ta();
    t_atomic_normal();
    t_proto();
    t_full();
    t_chain();
    t_flush_reset();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule